// File: doc/BRIEF.md
# Host Contention-Aware Message Controller

This block is the host-side sequencer that places messages onto a shared medium through a UART and a carrier transceiver. Each node that wants the channel first waits for the idle-line input to read 1. It then writes the first character of its message and listens for that character to come back. The transceiver returns either the node's own first character, which means the node won the channel, or the first character of the node that did win. The block compares the returned character with the one it sent. On a match it streams the rest of the message from a local buffer. On a mismatch it drops out and stores the foreign message in the same buffer.

A received message has no length field. Its end is taken as a quiet period of one and a half character times since the last character. The block measures this in bit ticks supplied by the host: 15 for 10-bit frames and 17 for 11-bit frames. After its own last character, a winning sender waits for the idle line to come back before it reports completion.

Top module: `host_msg_ctrl`

## Requirements
- R1: After reset, busy, done, lost, rxOverflow, uartTxWrite and bufWrEn are 0 and rxCount is 0.
- R2: A start pulse is accepted only while busy is 0. After start, the first character (buffer address 0) is written to the UART only in a cycle where idleLine and uartTxReady are both 1, and never while idleLine is 0.
- R3: After the first write, nothing more is written until a character is received. If that character equals the first one sent, the characters at addresses 1 to length-1 are written in address order, one in each cycle that uartTxReady is 1.
- R4: If the first received character differs from the one sent, lost rises in the next cycle. The character is written to buffer address 0 in that same cycle, and rxCount becomes 1.
- R5: While receiving a lost contest, each received character is written to the next buffer address (equal to rxCount) in the cycle it arrives, and rxCount then increments.
- R6: A received message ends on the cycle after the 15th bitTick (longFrame=0) or the 17th bitTick (longFrame=1) with no character received since the last one. A received character restarts the count, and a character wins over a tick in the same cycle.
- R7: A received character beyond buffer depth (32 by default) is not written, rxCount stays at depth, and rxOverflow goes to 1 and holds until the next accepted start.
- R8: After the last character of a won message, done waits for idleLine to be 1. Characters received while sending or draining are not stored, and lost stays 0.
- R9: A msgLen of 0 sends one character, and a msgLen above depth is clamped to depth. For a one-character message a matching echo goes straight to the wait for idle.
- R10: done is a one-cycle pulse, and busy is 0 in the cycle after it. An accepted start clears lost, rxOverflow and rxCount.
- R11: Characters received while busy is 0 are not stored and do not change rxCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| start | input | 1 | request to send the buffered message |
| msgLen | input | ADDR_W+1 | characters to send, sampled at start |
| longFrame | input | 1 | 1 selects 11-bit frames for the quiet timeout |
| idleLine | input | 1 | 1 when the medium is idle |
| bitTick | input | 1 | one pulse per bit time |
| bufRdAddr | output | ADDR_W | transmit buffer read address |
| bufRdData | input | DATA_W | transmit buffer read data (combinational) |
| bufWrEn | output | 1 | receive buffer write strobe |
| bufWrAddr | output | ADDR_W | receive buffer write address |
| bufWrData | output | DATA_W | receive buffer write data |
| uartTxReady | input | 1 | UART transmit buffer free |
| uartTxWrite | output | 1 | write strobe to the UART |
| uartTxData | output | DATA_W | character to the UART |
| uartRxValid | input | 1 | UART received-character strobe |
| uartRxData | input | DATA_W | received character |
| busy | output | 1 | a message exchange is in progress |
| done | output | 1 | one-cycle end-of-message pulse |
| lost | output | 1 | contention was lost for the current message |
| rxOverflow | output | 1 | received message exceeded the buffer |
| rxCount | output | ADDR_W+1 | characters stored for the received message |

## Verification
A wrong phase in the sequencer shows at the ports within one cycle. Buffer or UART strobes appear when they should not, or are missing when they should appear. The bench compares every strobe, address and data word against its own model on every clock, so a wrong phase is reported in the cycle it occurs. A wrong character index or quiet count stays hidden until the next write or tick. It then shows as a wrong buffer address, wrong data, or a done pulse that comes early or late by some number of ticks. Sticky lost and overflow flags are checked every cycle, so a flag that clears early or sets without cause is caught at once.

// File: rtl/host_msg_pkg.sv
package host_msg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_WAIT_ECHO,
    ST_SEND,
    ST_DRAIN,
    ST_RECV,
    ST_DONE
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armMsg;
    logic sendChar;
    logic latchFirst;
    logic captureRx;
    logic markLost;
    logic markOverflow;
    logic quietClear;
    logic quietStep;
  } ctl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic echoMatch;
    logic lastChar;
    logic singleChar;
    logic rxFull;
    logic quietDone;
  } stat_t;

endpackage

// File: rtl/host_msg_ctrl_dp.sv
module host_msg_ctrl_dp
  import host_msg_pkg::*;
#(
  parameter int DATA_W           = 9,
  parameter int ADDR_W           = 5,
  parameter int SHORT_FRAME_BITS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  output stat_t             stat,
  input  logic [ADDR_W:0]   msgLen,
  input  logic              longFrame,
  input  logic [DATA_W-1:0] bufRdData,
  input  logic [DATA_W-1:0] uartRxData,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [DATA_W-1:0] bufWrData,
  output logic [DATA_W-1:0] uartTxData,
  output logic              lost,
  output logic              rxOverflow,
  output logic [ADDR_W:0]   rxCount
);

  localparam int CNT_W       = ADDR_W + 1;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int QUIET_SHORT = (3 * SHORT_FRAME_BITS + 1) / 2;
  localparam int QUIET_LONG  = (3 * (SHORT_FRAME_BITS + 1) + 1) / 2;
  localparam int Q_W         = $clog2(QUIET_LONG + 1);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [Q_W-1:0]   QS_LAST = Q_W'(QUIET_SHORT - 1);
  localparam logic [Q_W-1:0]   QL_LAST = Q_W'(QUIET_LONG - 1);
  localparam logic [Q_W-1:0]   QL_MAX  = Q_W'(QUIET_LONG);

  logic [CNT_W-1:0]  txIdx;
  logic [CNT_W-1:0]  lenReg;
  logic [CNT_W-1:0]  lenClamp;
  logic [CNT_W-1:0]  rxIdx;
  logic [DATA_W-1:0] firstChar;
  logic [Q_W-1:0]    quietCnt;
  logic              lostFlag;
  logic              ovfFlag;

  always_comb begin
    if (msgLen == '0)          lenClamp = ONE_C;
    else if (msgLen > DEPTH_C) lenClamp = DEPTH_C;
    else                       lenClamp = msgLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIdx     <= '0;
      lenReg    <= ONE_C;
      rxIdx     <= '0;
      firstChar <= '0;
      quietCnt  <= '0;
      lostFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (ctl.armMsg) begin
        txIdx    <= '0;
        rxIdx    <= '0;
        lenReg   <= lenClamp;
        lostFlag <= 1'b0;
        ovfFlag  <= 1'b0;
        quietCnt <= '0;
      end
      if (ctl.sendChar)     txIdx     <= txIdx + ONE_C;
      if (ctl.latchFirst)   firstChar <= bufRdData;
      if (ctl.captureRx)    rxIdx     <= rxIdx + ONE_C;
      if (ctl.markLost)     lostFlag  <= 1'b1;
      if (ctl.markOverflow) ovfFlag   <= 1'b1;
      if (ctl.quietClear)      quietCnt <= '0;
      else if (ctl.quietStep)  quietCnt <= quietCnt + Q_W'(1);
    end
  end

  always_comb begin
    stat.echoMatch  = (uartRxData == firstChar);
    stat.lastChar   = (txIdx == lenReg - ONE_C);
    stat.singleChar = (lenReg == ONE_C);
    stat.rxFull     = (rxIdx == DEPTH_C);
    stat.quietDone  = (quietCnt == (longFrame ? QL_LAST : QS_LAST));
  end

  assign bufRdAddr  = txIdx[ADDR_W-1:0];
  assign uartTxData = bufRdData;
  assign bufWrAddr  = rxIdx[ADDR_W-1:0];
  assign bufWrData  = uartRxData;
  assign lost       = lostFlag;
  assign rxOverflow = ovfFlag;
  assign rxCount    = rxIdx;

  // R3
  tx_index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sendChar |=> (txIdx == $past(txIdx) + ONE_C));

  // R5
  rx_index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureRx |=> (rxIdx == $past(rxIdx) + ONE_C) && (rxIdx <= DEPTH_C));

  // R4
  lost_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostFlag) |-> $past(ctl.captureRx) && (rxIdx == ONE_C));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ctl.armMsg) |=> ovfFlag);

  // R6
  quiet_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt < QL_MAX);

endmodule

// File: rtl/host_msg_ctrl_fsm.sv
module host_msg_ctrl_fsm
  import host_msg_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  idleLine,
  input  logic  bitTick,
  input  logic  uartTxReady,
  input  logic  uartRxValid,
  input  stat_t stat,
  output ctl_t  ctl,
  output logic  busy,
  output logic  done
);

  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.armMsg = 1'b1;
          nextState  = ST_WAIT_IDLE;
        end
      end
      ST_WAIT_IDLE: begin
        if (idleLine && uartTxReady) begin
          ctl.sendChar   = 1'b1;
          ctl.latchFirst = 1'b1;
          nextState      = ST_WAIT_ECHO;
        end
      end
      ST_WAIT_ECHO: begin
        if (uartRxValid) begin
          if (stat.echoMatch) begin
            nextState = stat.singleChar ? ST_DRAIN : ST_SEND;
          end else begin
            ctl.captureRx  = 1'b1;
            ctl.markLost   = 1'b1;
            ctl.quietClear = 1'b1;
            nextState      = ST_RECV;
          end
        end
      end
      ST_SEND: begin
        if (uartTxReady) begin
          ctl.sendChar = 1'b1;
          if (stat.lastChar) nextState = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (idleLine) nextState = ST_DONE;
      end
      ST_RECV: begin
        if (uartRxValid) begin
          ctl.quietClear = 1'b1;
          if (stat.rxFull) ctl.markOverflow = 1'b1;
          else             ctl.captureRx    = 1'b1;
        end else if (bitTick) begin
          if (stat.quietDone) nextState     = ST_DONE;
          else                ctl.quietStep = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R2
  first_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_ECHO && $past(state) == ST_WAIT_IDLE) |-> $past(idleLine));

endmodule

// File: rtl/host_msg_ctrl.sv
module host_msg_ctrl
  import host_msg_pkg::*;
#(
  parameter int DATA_W           = 9,
  parameter int ADDR_W           = 5,
  parameter int SHORT_FRAME_BITS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   msgLen,
  input  logic              longFrame,
  input  logic              idleLine,
  input  logic              bitTick,
  output logic [ADDR_W-1:0] bufRdAddr,
  input  logic [DATA_W-1:0] bufRdData,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [DATA_W-1:0] bufWrData,
  input  logic              uartTxReady,
  output logic              uartTxWrite,
  output logic [DATA_W-1:0] uartTxData,
  input  logic              uartRxValid,
  input  logic [DATA_W-1:0] uartRxData,
  output logic              busy,
  output logic              done,
  output logic              lost,
  output logic              rxOverflow,
  output logic [ADDR_W:0]   rxCount
);

  ctl_t  ctl;
  stat_t stat;

  host_msg_ctrl_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .idleLine    (idleLine),
    .bitTick     (bitTick),
    .uartTxReady (uartTxReady),
    .uartRxValid (uartRxValid),
    .stat        (stat),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done)
  );

  host_msg_ctrl_dp #(
    .DATA_W           (DATA_W),
    .ADDR_W           (ADDR_W),
    .SHORT_FRAME_BITS (SHORT_FRAME_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .stat       (stat),
    .msgLen     (msgLen),
    .longFrame  (longFrame),
    .bufRdData  (bufRdData),
    .uartRxData (uartRxData),
    .bufRdAddr  (bufRdAddr),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .uartTxData (uartTxData),
    .lost       (lost),
    .rxOverflow (rxOverflow),
    .rxCount    (rxCount)
  );

  assign uartTxWrite = ctl.sendChar;
  assign bufWrEn     = ctl.captureRx;

endmodule

// File: tb/host_msg_ctrl_test.sv
module host_msg_ctrl_test;
  localparam int DW = 9;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, longFrame = 1'b0, idleLine = 1'b0, bitTick = 1'b0;
  logic uartTxReady = 1'b0, uartRxValid = 1'b0;
  logic [AW:0] msgLen = '0;
  logic [DW-1:0] uartRxData = '0;
  logic [AW-1:0] bufRdAddr, bufWrAddr;
  logic [DW-1:0] bufRdData, bufWrData, uartTxData;
  logic bufWrEn, uartTxWrite, busy, done, lost, rxOverflow;
  logic [AW:0] rxCount;

  logic [DW-1:0] txMem [DEPTH];
  logic [DW-1:0] rxMem [DEPTH];
  assign bufRdData = txMem[bufRdAddr];

  always #5 clk = ~clk;

  host_msg_ctrl uut (.*);

  int checks = 0, fails = 0, txWrites = 0, cycleCount = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (bufWrEn) rxMem[bufWrAddr] <= bufWrData;
    if (uartTxWrite) txWrites++;
    cycleCount++;
    if (cycleCount > 50000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=50000 cycles", cycleCount);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // behavioural reference: phases 0 idle,1 wait idle,2 wait echo,3 send,4 drain,5 receive,6 done
  int mPh = 0, mTx = 0, mLen = 1, mFirst = 0, mRx = 0, mQuiet = 0;
  bit mLost = 0, mOvf = 0;

  always @(negedge clk) begin
    bit eW, eR;
    int lim;
    eW = (mPh == 1 && idleLine && uartTxReady) || (mPh == 3 && uartTxReady);
    eR = uartRxValid && ((mPh == 2 && int'(uartRxData) != mFirst) || (mPh == 5 && mRx < DEPTH));
    chk("R3", "tx write", uartTxWrite, eW);
    if (eW) chk("R3", "tx data", uartTxData, txMem[mTx]);
    chk("R5", "buf write", bufWrEn, eR);
    if (eR) begin
      chk("R5", "buf addr", bufWrAddr, mRx);
      chk("R5", "buf data", bufWrData, uartRxData);
    end
    chk("R6", "done", done, mPh == 6);
    chk("R10", "busy", busy, mPh != 0);
    chk("R4", "lost", lost, mLost);
    chk("R7", "overflow", rxOverflow, mOvf);
    chk("R5", "rxCount", rxCount, mRx);
    lim = longFrame ? 17 : 15;
    if (!rstN) begin
      mPh = 0; mTx = 0; mLen = 1; mFirst = 0; mRx = 0; mQuiet = 0; mLost = 0; mOvf = 0;
    end else begin
      case (mPh)
        0: if (start) begin
             mPh = 1; mTx = 0; mRx = 0; mLost = 0; mOvf = 0; mQuiet = 0;
             mLen = (msgLen == 0) ? 1 : ((int'(msgLen) > DEPTH) ? DEPTH : int'(msgLen));
           end
        1: if (idleLine && uartTxReady) begin mFirst = txMem[0]; mTx = 1; mPh = 2; end
        2: if (uartRxValid) begin
             if (int'(uartRxData) == mFirst) mPh = (mLen == 1) ? 4 : 3;
             else begin mLost = 1; mRx = 1; mQuiet = 0; mPh = 5; end
           end
        3: if (uartTxReady) begin
             if (mTx == mLen - 1) mPh = 4;
             mTx++;
           end
        4: if (idleLine) mPh = 6;
        5: if (uartRxValid) begin
             mQuiet = 0;
             if (mRx < DEPTH) mRx++; else mOvf = 1;
           end else if (bitTick) begin
             if (mQuiet == lim - 1) mPh = 6; else mQuiet++;
           end
        default: mPh = 0;
      endcase
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rxChar(logic [DW-1:0] d);
    uartRxValid = 1'b1; uartRxData = d; cyc(1); uartRxValid = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin bitTick = 1'b1; cyc(1); bitTick = 1'b0; cyc(2); end
  endtask

  task automatic startMsg(int len);
    start = 1'b1; msgLen = (AW+1)'(len); cyc(1); start = 1'b0;
  endtask

  initial begin
    int w0;
    for (int i = 0; i < DEPTH; i++) txMem[i] = DW'(i * 7 + 3);
    cyc(3);
    @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset lost", lost, 0);
    chk("R1", "reset tx write", uartTxWrite, 0);
    chk("R1", "reset rxCount", rxCount, 0);
    @(posedge clk); #1 rstN = 1'b1;
    cyc(2);

    // won contest, 4 characters
    w0 = txWrites;
    uartTxReady = 1'b1; idleLine = 1'b0;
    startMsg(4);
    cyc(3);
    chk("R2", "no write while line busy", txWrites - w0, 0);
    idleLine = 1'b1; cyc(1);
    idleLine = 1'b0; uartTxReady = 1'b0;
    cyc(2);
    chk("R3", "one write before echo", txWrites - w0, 1);
    rxChar(txMem[0]);
    uartTxReady = 1'b1; uartRxValid = 1'b1; uartRxData = 9'h05;
    cyc(1);
    uartRxValid = 1'b0;
    cyc(2);
    uartTxReady = 1'b0;
    cyc(3);
    chk("R3", "all characters written", txWrites - w0, 4);
    chk("R8", "waits for idle line", busy, 1);
    chk("R8", "not lost", lost, 0);
    idleLine = 1'b1; cyc(1);
    @(negedge clk);
    chk("R8", "done after idle", done, 1);
    cyc(2);

    // lost contest, short frames
    txMem[0] = 9'h0A5;
    startMsg(3);
    uartTxReady = 1'b1; cyc(1);
    uartTxReady = 1'b0; idleLine = 1'b0;
    rxChar(9'h05A);
    @(negedge clk);
    chk("R4", "lost raised", lost, 1);
    cyc(1);
    ticks(5); rxChar(9'h101);
    ticks(14); rxChar(9'h102);
    ticks(2); rxChar(9'h103);
    ticks(14);
    chk("R6", "still busy after 14 ticks", busy, 1);
    ticks(1);
    chk("R6", "ended after 15 ticks", busy, 0);
    chk("R4", "first foreign char at 0", rxMem[0], 9'h05A);
    chk("R5", "third foreign char", rxMem[2], 9'h102);
    chk("R5", "count", rxCount, 4);
    idleLine = 1'b1;
    rxChar(9'h033);
    cyc(1);
    chk("R11", "idle char not stored", rxCount, 4);

    // lost contest, long frames
    longFrame = 1'b1;
    startMsg(2);
    uartTxReady = 1'b1; cyc(1); uartTxReady = 1'b0;
    rxChar(9'h1FF);
    ticks(16); rxChar(9'h0EE);
    ticks(16);
    chk("R6", "long frame busy at 16", busy, 1);
    ticks(1);
    chk("R6", "long frame ended at 17", busy, 0);
    chk("R5", "long count", rxCount, 2);
    longFrame = 1'b0;

    // overflow
    startMsg(1);
    uartTxReady = 1'b1; cyc(1); uartTxReady = 1'b0;
    rxChar(9'h1F0);
    for (int k = 1; k < DEPTH + 2; k++) rxChar(DW'(k + 40));
    @(negedge clk);
    chk("R7", "overflow flag", rxOverflow, 1);
    chk("R7", "count held at depth", rxCount, DEPTH);
    chk("R7", "last stored", rxMem[DEPTH-1], DW'(DEPTH - 1 + 40));
    cyc(1);
    ticks(15);
    chk("R7", "overflow sticky after end", rxOverflow, 1);

    // zero length, one character won
    w0 = txWrites;
    startMsg(0);
    @(negedge clk);
    chk("R10", "start clears overflow", rxOverflow, 0);
    chk("R10", "start clears count", rxCount, 0);
    cyc(1);
    uartTxReady = 1'b1; cyc(1); uartTxReady = 1'b0;
    rxChar(txMem[0]);
    cyc(3);
    chk("R9", "single write", txWrites - w0, 1);
    chk("R9", "finished", busy, 0);
    cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule